// File: doc/BRIEF.md
# Fetch-to-Decode Instruction Queue

This block is the in-order holding queue between instruction fetch and decode in a superscalar front end. Each cycle fetch offers a group of four instruction slots with a count of how many leading slots carry real instructions. A group can be short when the fetch address lands near the end of a cache line, or when a predicted-taken branch cuts it off. Only the slots marked valid are kept.

Decode sees the four oldest held instructions on four output lanes, with lane 0 always the oldest. It then reports how many of them it took, and the read position moves forward by that amount. Decode may take fewer than four, so the next read window can start at any entry.

Storage is four interleaved banks, each with one write port. Entry `e` lives in bank `e mod 4`, so a four-entry write window or read window touches each bank exactly once. The bank outputs are rotated back into program order before they reach the lanes. A flush empties the queue in one cycle.

Top module: `fetch_queue`

## Requirements
- R1: While reset is asserted and right after it, `empty` is 1, `full` is 0, `wr_ready` is 1 and `rd_valid` is 0.
- R2: An accepted write stores slots 0 to `wr_cnt`-1 of `wr_data` in that order, with slot k at bits [32k+31:32k], behind all older entries. A `wr_cnt` above 4 counts as 4, and a `wr_cnt` of 0 stores nothing.
- R3: `wr_ready` is 1 exactly when at least four entries are free. A write offered while `wr_ready` is 0 is ignored and changes no output.
- R4: Output lane j, at bits [32j+31:32j] of `rd_data`, holds the j-th oldest held instruction. This holds whatever the alignment of the oldest entry within the banks.
- R5: `rd_valid[j]` is 1 exactly when more than j instructions are held, so the valid lanes always form a run starting at lane 0.
- R6: Each cycle the oldest min(`rd_cnt`, 4, occupancy) instructions are removed. When `rd_cnt` is 0 or the queue is empty, nothing is removed.
- R7: When a read and a write occur in the same cycle, occupancy becomes the old occupancy plus the number written minus the number removed. Whether the write is accepted is decided from the occupancy before that cycle.
- R8: A flush empties the queue in one cycle. It overrides a write or a read presented in the same cycle, and neither of them has any effect.
- R9: `full` is 1 exactly when DEPTH instructions are held, and `empty` is 1 exactly when none are held.
- R10: Storage positions wrap modulo DEPTH, and program order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue this cycle |
| wr_req | input | 1 | Fetch offers a group |
| wr_cnt | input | 3 | Number of leading valid slots in the group |
| wr_data | input | 128 | Four 32-bit instruction slots, slot 0 in the low bits |
| wr_ready | output | 1 | At least four entries are free |
| rd_cnt | input | 3 | Number of instructions decode consumed |
| rd_data | output | 128 | Four lanes in program order, lane 0 in the low bits |
| rd_valid | output | 4 | Per-lane valid |
| full | output | 1 | Queue holds DEPTH instructions |
| empty | output | 1 | Queue holds nothing |

## Verification
The bench targets read windows that start at every bank offset and windows that straddle the wrap of the storage positions. A rotation or row-address error there would put instructions on the wrong lane or mix in stale ones. It offers writes while fewer than four entries are free, including while the queue is full, and offers read counts above the occupancy and above four. A design that stored those writes would overwrite live entries, and one that trusted those read counts would underflow its occupancy. Groups carrying 0, partial, 4 and oversize counts check that filler slots never enter the queue. A flush presented together with a read and a write checks that neither of them leaks through.

// File: rtl/fq_pkg.sv
package fq_pkg;
  function automatic int unsigned fq_min(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/fq_ctrl.sv
module fq_ctrl
  import fq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int CNTW = $clog2(LANES + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            wr_req,
  input  logic [CNTW-1:0] wr_cnt,
  input  logic [CNTW-1:0] rd_cnt,
  output logic [PW-1:0]   wptr,
  output logic [PW-1:0]   rptr,
  output logic [OW-1:0]   count,
  output logic [CNTW-1:0] wr_take,
  output logic [CNTW-1:0] rd_take,
  output logic            wr_ready,
  output logic            full,
  output logic            empty
);
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [OW-1:0] cnt_q, cnt_d;
  logic          wr_fire;
  logic          upd;

  always_comb begin
    wr_ready = (int'(cnt_q) <= DEPTH - LANES);
    wr_fire  = wr_req && wr_ready && !flush;
    wr_take  = wr_fire ? CNTW'(fq_min(int'(wr_cnt), LANES)) : '0;
    rd_take  = flush ? '0
             : CNTW'(fq_min(fq_min(int'(rd_cnt), LANES), int'(cnt_q)));
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      wptr_d = wptr_q + PW'(wr_take);
      rptr_d = rptr_q + PW'(rd_take);
      cnt_d  = cnt_q + OW'(wr_take) - OW'(rd_take);
    end
    upd = flush || (wr_take != '0) || (rd_take != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign count = cnt_q;
  assign full  = (int'(cnt_q) == DEPTH);
  assign empty = (cnt_q == '0);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);
  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && wptr_q == '0 && rptr_q == '0));
  assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ready && !flush) |=> (cnt_q == $past(cnt_q) - OW'($past(rd_take))));
  assert_wptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (wptr_q == $past(wptr_q) + PW'($past(wr_take))));
  assert_rptr_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && rd_cnt != '0 && cnt_q != '0) |=> (rptr_q != $past(rptr_q)));
endmodule

// File: rtl/fq_bank.sv
module fq_bank #(
  parameter int W = 32,
  parameter int ROWS = 4,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [RW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fq_wsteer.sv
module fq_wsteer #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int CNTW = $clog2(LANES + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int LB = $clog2(LANES),
  localparam int RW = PW - LB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PW-1:0]      wptr,
  input  logic [CNTW-1:0]    wr_take,
  input  logic [LANES*W-1:0] wr_data,
  output logic [LANES-1:0]   bank_we,
  output logic [LANES*RW-1:0] bank_waddr,
  output logic [LANES*W-1:0] bank_wdata
);
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LB-1:0] slot;
    logic [PW-1:0] entry;
    always_comb begin
      slot  = LB'(b) - wptr[LB-1:0];
      entry = wptr + PW'(slot);
      bank_we[b] = (CNTW'(slot) < wr_take);
      bank_waddr[b*RW +: RW] = entry[PW-1:LB];
      bank_wdata[b*W +: W]   = wr_data[slot*W +: W];
    end
  end

  assert_we_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_we) == int'(wr_take));
endmodule

// File: rtl/fq_rotate.sv
module fq_rotate #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int LB = $clog2(LANES),
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES*W-1:0] bank_q,
  input  logic [LB-1:0]      base,
  input  logic [OW-1:0]      count,
  output logic [LANES*W-1:0] rd_data,
  output logic [LANES-1:0]   rd_valid
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LB-1:0] src;
    always_comb begin
      src = LB'(j) + base;
      rd_data[j*W +: W] = bank_q[src*W +: W];
      rd_valid[j] = (int'(count) > j);
    end
  end

  assert_valid_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid & (rd_valid + 1'b1)) == '0);
  assert_lane0_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> rd_valid[0]);
endmodule

// File: rtl/fetch_queue.sv
module fetch_queue #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int CNTW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_req,
  input  logic [CNTW-1:0]    wr_cnt,
  input  logic [LANES*W-1:0] wr_data,
  output logic               wr_ready,
  input  logic [CNTW-1:0]    rd_cnt,
  output logic [LANES*W-1:0] rd_data,
  output logic [LANES-1:0]   rd_valid,
  output logic               full,
  output logic               empty
);
  localparam int PW   = $clog2(DEPTH);
  localparam int OW   = $clog2(DEPTH + 1);
  localparam int LB   = $clog2(LANES);
  localparam int ROWS = DEPTH / LANES;
  localparam int RW   = PW - LB;

  logic [PW-1:0]       wptr, rptr;
  logic [OW-1:0]       count;
  logic [CNTW-1:0]     wr_take, rd_take;
  logic [LANES-1:0]    bank_we;
  logic [LANES*RW-1:0] bank_waddr;
  logic [LANES*W-1:0]  bank_wdata;
  logic [LANES*W-1:0]  bank_q;

  fq_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_req(wr_req),
    .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .wptr(wptr), .rptr(rptr),
    .count(count), .wr_take(wr_take), .rd_take(rd_take),
    .wr_ready(wr_ready), .full(full), .empty(empty)
  );

  fq_wsteer #(.W(W), .DEPTH(DEPTH), .LANES(LANES)) u_wsteer (
    .clk(clk), .rst_n(rst_n), .wptr(wptr), .wr_take(wr_take),
    .wr_data(wr_data), .bank_we(bank_we), .bank_waddr(bank_waddr),
    .bank_wdata(bank_wdata)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LB-1:0] lane;
    logic [PW-1:0] entry;
    logic [RW-1:0] raddr;
    always_comb begin
      lane  = LB'(b) - rptr[LB-1:0];
      entry = rptr + PW'(lane);
      raddr = entry[PW-1:LB];
    end
    fq_bank #(.W(W), .ROWS(ROWS)) u_bank (
      .clk(clk), .we(bank_we[b]), .waddr(bank_waddr[b*RW +: RW]),
      .wdata(bank_wdata[b*W +: W]), .raddr(raddr),
      .rdata(bank_q[b*W +: W])
    );
  end

  fq_rotate #(.W(W), .DEPTH(DEPTH), .LANES(LANES)) u_rotate (
    .clk(clk), .rst_n(rst_n), .bank_q(bank_q), .base(rptr[LB-1:0]),
    .count(count), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_ready);
endmodule

// File: tb/fetch_queue_bench.sv
module fetch_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int DEPTH = 16;
  localparam int LANES = 4;
  localparam int NVEC = 26;
  // vector: [7] flush, [6] wr_req, [5:3] wr_cnt, [2:0] rd_cnt
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0_1_100_000, // R2 full group          -> 4
    8'b0_1_011_000, // R2 partial group       -> 7
    8'b0_0_000_001, // R6 unaligned start     -> 6
    8'b0_1_010_011, // R7 read+write          -> 5
    8'b0_1_100_000, //                        -> 9
    8'b0_1_100_000, //                        -> 13
    8'b0_1_100_000, // R3 refused, free 3     -> 13
    8'b0_1_011_010, // R3/R7 refused + read   -> 11
    8'b0_1_100_000, //                        -> 15
    8'b0_1_001_011, // R3 refused, read 3     -> 12
    8'b0_1_100_000, // R9 full                -> 16
    8'b0_1_100_000, // R3 refused when full   -> 16
    8'b0_0_000_100, // R10 wrap region        -> 12
    8'b0_0_000_100, //                        -> 8
    8'b0_1_111_000, // R2 oversize count      -> 12
    8'b0_0_000_111, // R6 oversize read       -> 8
    8'b0_1_001_010, // R7                     -> 7
    8'b1_1_100_010, // R8 flush wins          -> 0
    8'b0_0_000_011, // R6 read on empty       -> 0
    8'b0_1_010_000, //                        -> 2
    8'b0_0_000_100, // R6 read past occupancy -> 0
    8'b0_1_100_000, //                        -> 4
    8'b0_1_100_100, // R7                     -> 4
    8'b0_1_011_001, // R4 offset              -> 6
    8'b1_0_000_000, // R8 flush               -> 0
    8'b0_1_000_000  // R2 zero count          -> 0
  };

  logic clk = 1'b0;
  logic rst_n;
  logic flush, wr_req, wr_ready, full, empty;
  logic [2:0] wr_cnt, rd_cnt;
  logic [LANES*W-1:0] wr_data, rd_data;
  logic [LANES-1:0] rd_valid;

  int n_chk = 0;
  int n_fail = 0;
  int seq = 0;
  bit done = 0;
  logic [W-1:0] mq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_queue #(.W(W), .DEPTH(DEPTH), .LANES(LANES)) u_fetch_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_req(wr_req),
    .wr_cnt(wr_cnt), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_cnt(rd_cnt), .rd_data(rd_data), .rd_valid(rd_valid),
    .full(full), .empty(empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    int sz = mq.size();
    for (int j = 0; j < LANES; j++) begin
      bit v = (j < sz);
      chk(rd_valid[j] == v, "R5 lane valid", 64'(rd_valid[j]), 64'(v));
      if (v) chk(rd_data[j*W +: W] == mq[j], "R4 lane data", 64'(rd_data[j*W +: W]), 64'(mq[j]));
    end
    chk(empty == (sz == 0), "R9 empty", 64'(empty), 64'(sz == 0));
    chk(full == (sz == DEPTH), "R9 full", 64'(full), 64'(sz == DEPTH));
    chk(wr_ready == (DEPTH - sz >= 4), "R3 wr_ready", 64'(wr_ready), 64'(DEPTH - sz >= 4));
  endtask

  task automatic apply(input logic [7:0] v);
    int wc = int'(v[5:3]);
    int rc = int'(v[2:0]);
    int sz = mq.size();
    bit fire = v[6] && (DEPTH - sz >= 4) && !v[7];
    int rt, wt;
    flush = v[7]; wr_req = v[6]; wr_cnt = v[5:3]; rd_cnt = v[2:0];
    for (int k = 0; k < LANES; k++)
      wr_data[k*W +: W] = (k < wc) ? W'(32'hC0DE_0000 + seq + k) : W'(32'hBAD0_0000 + k);
    @(posedge clk);
    if (v[7]) mq.delete();
    else begin
      rt = (rc > 4) ? 4 : rc;
      if (rt > sz) rt = sz;
      for (int k = 0; k < rt; k++) void'(mq.pop_front());
      if (fire) begin
        wt = (wc > 4) ? 4 : wc;
        for (int k = 0; k < wt; k++) mq.push_back(W'(32'hC0DE_0000 + seq + k));
        seq += wt;
      end
    end
    @(negedge clk);
    flush = 0; wr_req = 0; wr_cnt = 0; rd_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush = 0; wr_req = 0; wr_cnt = 0; rd_cnt = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(empty == 1'b1, "R1 empty in reset", 64'(empty), 64'd1);
    chk(full == 1'b0, "R1 full in reset", 64'(full), 64'd0);
    chk(wr_ready == 1'b1, "R1 wr_ready in reset", 64'(wr_ready), 64'd1);
    chk(rd_valid == '0, "R1 rd_valid in reset", 64'(rd_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check_outputs();
    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i]);
      check_outputs();
    end
    // directed R10: long stream of odd-sized groups through several wraps
    for (int i = 0; i < 40; i++) begin
      apply({1'b0, 1'b1, 3'(1 + i % 4), 3'(1 + (i * 3) % 4)});
      check_outputs();
    end
    // directed R1: reset in mid-run empties the queue
    apply(8'b0_1_100_000);
    rst_n = 0;
    mq.delete();
    @(negedge clk);
    chk(empty == 1'b1, "R1 empty after mid-run reset", 64'(empty), 64'd1);
    chk(rd_valid == '0, "R1 rd_valid after mid-run reset", 64'(rd_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule